// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries of a page table that lives in main memory. A caller presents one translation request at a time. The request carries the virtual address, whether the access is a write, whether it comes from user mode, and the byte address of the root (directory) table. The walker then issues two word reads through a simple memory port. The first read fetches the directory entry. The second fetches the leaf entry from the table that the directory entry names.

At each level the walker inspects the fetched entry. If the entry is absent, the walk stops with a not-present fault. If the entry forbids the access, the walk stops with a protection fault. When both levels pass, the walker reports the physical address together with the attribute bits of the leaf entry. Every outcome, success or fault, is announced by a single-cycle `done` pulse. A new request is taken only while the walker is idle.

The memory port may answer a read any number of cycles after it is asked. The walker keeps its read request and address steady until the answer arrives.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, while `mem_req` and `done` are 0.
- R2: The first read goes to address `{table_root[31:12], 12'h000} + 4*va[31:22]`. The low 12 bits of `table_root` are ignored, and every read address is word aligned.
- R3: The second read goes to address `{dir_entry[31:12], 12'h000} + 4*va[21:12]`.
- R4: A successful walk reports `fault_code` 0, `paddr = {leaf[31:12], va[11:0]}` and `attr = leaf[11:0]`. The attribute bits (referenced, dirty, global and so on) are passed through without being interpreted.
- R5: An entry with bit 0 (present) clear ends the walk with `fault_code` 1. `fault_lvl` is 0 for the directory level and 1 for the leaf level, and no further read is issued after the fault.
- R6: A present entry raises `fault_code` 2 (protection) in two cases: on a write when bit 1 (writable) is clear, and on a user access when bit 2 (user) is clear. A not-present fault takes priority over a protection fault. A supervisor read never causes a protection fault.
- R7: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until `mem_rsp_valid` is accepted. `mem_rsp_valid` has no effect while no read is outstanding.
- R8: `done` lasts exactly one cycle. `req_ready` is high only when the walker is idle, and a request presented while the walker is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| table_root | input | 32 | Byte address of the directory table, sampled with the request |
| mem_req | output | 1 | Word read request, held until answered |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 0 ok, 1 not present, 2 protection |
| fault_lvl | output | 1 | Level of the fault: 0 directory, 1 leaf |
| paddr | output | 32 | Translated physical address |
| attr | output | 12 | Low 12 bits of the leaf entry |

## Verification
The assertions check the port-level protocol on every cycle. They confirm that the read request and its address stay steady until answered, that read addresses are word aligned, that `done` is a single-cycle pulse with no read open while it is high, that `req_ready` never overlaps an outstanding read, and that no undefined fault code appears. The arithmetic of the two read addresses, the final physical address, and the choice between not-present and protection faults (including which level reports it) depend on entry contents. Only the bench's scenarios can show these behaviours, by comparing each walk against values it derives from the requirements.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ_DIR,
      ST_WAIT_DIR,
      ST_READ_PTE,
      ST_WAIT_PTE,
      ST_DONE,
      ST_FAULT
   } walk_state_t;

   localparam logic [1:0] FLT_NONE    = 2'd0;
   localparam logic [1:0] FLT_ABSENT  = 2'd1;
   localparam logic [1:0] FLT_PROTECT = 2'd2;

   // flag positions inside an entry
   localparam int FLG_PRESENT  = 0;
   localparam int FLG_WRITABLE = 1;
   localparam int FLG_USER     = 2;
   localparam int FLG_W        = 3;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10,
   parameter int OFF_W  = 12,
   parameter int ESZ_LG = 2
) (
   input  logic [ADDR_W-OFF_W-1:0] frame,
   input  logic [IDX_W-1:0]        index,
   output logic [ADDR_W-1:0]       addr
);
   localparam int FRAME_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] page_base;
   logic [ADDR_W-1:0] slot_off;

   always_comb begin
      page_base = {frame, {OFF_W{1'b0}}};
      slot_off  = ADDR_W'(index) << ESZ_LG;
      addr      = page_base + slot_off;
   end

   if (FRAME_W < 1) begin : g_bad_frame
      $error("pgwalk_addr: frame field has no width");
   end
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm #(
   parameter bit CHECK_ACCESS = 1'b1
) (
   input  logic [pgwalk_pkg::FLG_W-1:0] flags,
   input  logic                         is_write,
   input  logic                         is_user,
   output logic [1:0]                   code
);
   import pgwalk_pkg::*;

   logic denied;

   if (CHECK_ACCESS) begin : g_full
      always_comb begin
         denied = (is_write && !flags[FLG_WRITABLE]) ||
                  (is_user  && !flags[FLG_USER]);
      end
   end else begin : g_presence_only
      logic unused_access;
      always_comb begin
         unused_access = is_write ^ is_user ^ flags[FLG_WRITABLE] ^ flags[FLG_USER];
         denied = 1'b0;
      end
   end

   always_comb begin
      if (!flags[FLG_PRESENT])
         code = FLT_ABSENT;
      else if (denied)
         code = FLT_PROTECT;
      else
         code = FLT_NONE;
   end

   always_comb begin
      if (!flags[FLG_PRESENT])
         AST_ABSENT_WINS: assert (code == FLT_ABSENT); // R6
      if (flags[FLG_PRESENT] && !is_write && !is_user)
         AST_SUPER_READ_OK: assert (code == FLT_NONE); // R6
   end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ESZ_LG      = 2,
   parameter bit DIR_PERM_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              req_write,
   input  logic              req_user,
   input  logic [ADDR_W-1:0] table_root,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              done,
   output logic [1:0]        fault_code,
   output logic              fault_lvl,
   output logic [ADDR_W-1:0] paddr,
   output logic [OFF_W-1:0]  attr
);
   import pgwalk_pkg::*;

   localparam int FRAME_W = ADDR_W - OFF_W;
   localparam int DIR_LO  = OFF_W + IDX_W;

   if (2 * IDX_W + OFF_W != ADDR_W) begin : g_bad_split
      $error("pgwalk_top: index and offset widths must fill the address");
   end
   if (IDX_W + ESZ_LG > OFF_W) begin : g_bad_table
      $error("pgwalk_top: one table must fit in one page");
   end
   if (OFF_W < FLG_W) begin : g_bad_flags
      $error("pgwalk_top: offset too narrow to hold entry flags");
   end

   walk_state_t           state_q;
   logic [ADDR_W-1:0]     va_q;
   logic                  wr_q, usr_q;
   logic [FRAME_W-1:0]    root_q;
   logic [FRAME_W-1:0]    leaf_tbl_q;
   logic [ADDR_W-1:0]     paddr_q;
   logic [OFF_W-1:0]      attr_q;
   logic [1:0]            code_q;
   logic                  lvl_q;

   logic                  at_dir;
   logic [FRAME_W-1:0]    sel_frame;
   logic [IDX_W-1:0]      sel_index;
   logic [1:0]            dir_code, pte_code;
   logic                  unused_root;

   assign unused_root = ^table_root[OFF_W-1:0];

   always_comb begin
      at_dir    = (state_q == ST_READ_DIR) || (state_q == ST_WAIT_DIR);
      sel_frame = at_dir ? root_q : leaf_tbl_q;
      sel_index = at_dir ? va_q[DIR_LO +: IDX_W] : va_q[OFF_W +: IDX_W];
   end

   pgwalk_addr #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ESZ_LG(ESZ_LG)
   ) u_addr (
      .frame(sel_frame),
      .index(sel_index),
      .addr (mem_addr)
   );

   pgwalk_perm #(.CHECK_ACCESS(DIR_PERM_EN)) u_dir_perm (
      .flags   (mem_rsp_data[FLG_W-1:0]),
      .is_write(wr_q),
      .is_user (usr_q),
      .code    (dir_code)
   );

   pgwalk_perm #(.CHECK_ACCESS(1'b1)) u_pte_perm (
      .flags   (mem_rsp_data[FLG_W-1:0]),
      .is_write(wr_q),
      .is_user (usr_q),
      .code    (pte_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         va_q       <= '0;
         wr_q       <= 1'b0;
         usr_q      <= 1'b0;
         root_q     <= '0;
         leaf_tbl_q <= '0;
         paddr_q    <= '0;
         attr_q     <= '0;
         code_q     <= FLT_NONE;
         lvl_q      <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= req_write;
               usr_q   <= req_user;
               root_q  <= table_root[ADDR_W-1:OFF_W];
               state_q <= ST_READ_DIR;
            end
            ST_READ_DIR: state_q <= ST_WAIT_DIR;
            ST_WAIT_DIR: if (mem_rsp_valid) begin
               if (dir_code != FLT_NONE) begin
                  code_q  <= dir_code;
                  lvl_q   <= 1'b0;
                  state_q <= ST_FAULT;
               end else begin
                  leaf_tbl_q <= mem_rsp_data[ADDR_W-1:OFF_W];
                  state_q    <= ST_READ_PTE;
               end
            end
            ST_READ_PTE: state_q <= ST_WAIT_PTE;
            ST_WAIT_PTE: if (mem_rsp_valid) begin
               if (pte_code != FLT_NONE) begin
                  code_q  <= pte_code;
                  lvl_q   <= 1'b1;
                  state_q <= ST_FAULT;
               end else begin
                  paddr_q <= {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
                  attr_q  <= mem_rsp_data[OFF_W-1:0];
                  code_q  <= FLT_NONE;
                  lvl_q   <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            ST_DONE, ST_FAULT: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready  = (state_q == ST_IDLE);
      mem_req    = (state_q == ST_READ_DIR) || (state_q == ST_WAIT_DIR) ||
                   (state_q == ST_READ_PTE) || (state_q == ST_WAIT_PTE);
      done       = (state_q == ST_DONE) || (state_q == ST_FAULT);
      fault_code = code_q;
      fault_lvl  = lvl_q;
      paddr      = paddr_q;
      attr       = attr_q;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr)); // R7
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[ESZ_LG-1:0] == '0); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_NO_READ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req && !req_ready); // R5
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req && !done); // R8
   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> mem_req && !req_ready); // R8
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> fault_code != 2'd3); // R6
endmodule

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [31:0] root;
      logic [31:0] va;
      logic        wr;
      logic        usr;
      logic [31:0] dent;
      logic [31:0] pte;
      logic [3:0]  lat;
      logic [1:0]  code;
      logic        lvl;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{32'h0010_0000, 32'h0040_3ABC, 1'b0, 1'b0, 32'h0020_0007, 32'h1234_5063, 4'd1, 2'd0, 1'b1}, // R4 supervisor read
      '{32'h0050_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0ABC_D007, 32'h7777_F007, 4'd3, 2'd0, 1'b1}, // R4 user write, top indices
      '{32'h0010_0000, 32'h0000_0000, 1'b0, 1'b0, 32'h0020_0006, 32'h0000_0000, 4'd2, 2'd1, 1'b0}, // R5 dir absent
      '{32'h0010_0000, 32'h8010_2004, 1'b0, 1'b0, 32'h0030_0001, 32'h1234_5006, 4'd1, 2'd1, 1'b1}, // R5 leaf absent
      '{32'h0010_0000, 32'h0040_1000, 1'b1, 1'b0, 32'h0020_0003, 32'h1234_5005, 4'd4, 2'd2, 1'b1}, // R6 write read-only
      '{32'h0010_0000, 32'h0C00_0010, 1'b0, 1'b1, 32'h0020_0003, 32'h1234_5007, 4'd1, 2'd2, 1'b0}, // R6 user at supervisor dir
      '{32'h0010_0000, 32'h0040_2FFF, 1'b1, 1'b1, 32'h0020_0007, 32'h0000_0000, 4'd2, 2'd1, 1'b1}, // R6 absent beats protect
      '{32'h0030_0FFF, 32'h1234_5678, 1'b0, 1'b0, 32'h0040_0001, 32'h00AB_C001, 4'd5, 2'd0, 1'b1}  // R2 root low bits, R6 super read
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [31:0] table_root = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done;
   logic [1:0]  fault_code;
   logic        fault_lvl;
   logic [31:0] paddr;
   logic [11:0] attr;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgwalk_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .table_root(table_root),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .fault_code(fault_code), .fault_lvl(fault_lvl),
      .paddr(paddr), .attr(attr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic wait_answer(input int lat, input logic [31:0] addr_exp,
                              input logic [31:0] data);
      for (int c = 0; c < lat; c++) begin
         req_valid = 1'b1;
         req_vaddr = 32'hDEAD_0000 + c;
         table_root = 32'h0F00_0000;
         @(negedge clk);
         chk(mem_req === 1'b1 && mem_addr === addr_exp, "R7", "held read",
             mem_addr, addr_exp);
         chk(req_ready === 1'b0 && done === 1'b0, "R8", "busy ready",
             {30'd0, req_ready, done}, 32'd0);
      end
      req_valid = 1'b0;
      mem_rsp_valid = 1'b1;
      mem_rsp_data = data;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data = 32'h0;
   endtask

   task automatic run_vec(input vec_t v);
      logic [31:0] a1, a2, pa;
      a1 = {v.root[31:12], 12'h000} + {20'd0, v.va[31:22], 2'b00};
      a2 = {v.dent[31:12], 12'h000} + {20'd0, v.va[21:12], 2'b00};
      pa = {v.pte[31:12], v.va[11:0]};
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = v.va;
      req_write = v.wr;
      req_user = v.usr;
      table_root = v.root;
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_req === 1'b1 && mem_addr === a1, "R2", "dir address", mem_addr, a1);
      wait_answer(int'(v.lat), a1, v.dent);
      if (!(v.code != 2'd0 && v.lvl == 1'b0)) begin
         chk(mem_req === 1'b1 && mem_addr === a2, "R3", "leaf address", mem_addr, a2);
         wait_answer(int'(v.lat), a2, v.pte);
      end
      chk(done === 1'b1, "R8", "done raised", {31'd0, done}, 32'd1);
      chk(mem_req === 1'b0, "R5", "no read at end", {31'd0, mem_req}, 32'd0);
      chk(fault_code === v.code, v.code == 2'd2 ? "R6" : (v.code == 2'd1 ? "R5" : "R4"),
          "fault code", {30'd0, fault_code}, {30'd0, v.code});
      if (v.code != 2'd0)
         chk(fault_lvl === v.lvl, "R5", "fault level", {31'd0, fault_lvl}, {31'd0, v.lvl});
      else begin
         chk(paddr === pa, "R4", "paddr", paddr, pa);
         chk(attr === v.pte[11:0], "R4", "attr", {20'd0, attr}, {20'd0, v.pte[11:0]});
      end
      @(negedge clk);
      chk(done === 1'b0 && req_ready === 1'b1, "R8", "done single cycle",
          {30'd0, done, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R1", "reset ready", {31'd0, req_ready}, 32'd1);
      chk(mem_req === 1'b0, "R1", "reset mem_req", {31'd0, mem_req}, 32'd0);
      chk(done === 1'b0, "R1", "reset done", {31'd0, done}, 32'd0);

      // R7: stray response while idle has no effect
      mem_rsp_valid = 1'b1;
      mem_rsp_data = 32'hFFFF_FFFF;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      @(negedge clk);
      chk(mem_req === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R7",
          "stray response ignored", {29'd0, mem_req, done, req_ready}, 32'd1);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R8: back-to-back walk right after completion
      run_vec(VECS[0]);

      // R1: reset in the middle of a walk returns to idle
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = 32'h0040_3ABC;
      table_root = 32'h0010_0000;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(req_ready === 1'b1 && mem_req === 1'b0, "R1", "reset mid walk",
          {30'd0, req_ready, mem_req}, 32'd2);

      finish_run();
   end
endmodule